// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power modes of a small microcontroller subsystem. The CPU places a mode request on a four-bit status input. The controller runs a one-cycle entry handshake and then applies that mode's gating to the clocks, the CPU, the high-frequency peripherals, the memory and the core supply. While asleep it watches five categorised wake-event inputs. Each mode accepts only its own subset of them.

An accepted wake starts a per-mode latency count. When the count expires, a one-cycle wake-ready strobe is issued. In the retained modes, the clocks return and the interrupt service runs. On the interrupt-return acknowledge, the controller either re-enters the same mode or stays active, depending on whether the request was cleared. In the two shutdown modes the core supply is removed, and the wake is delivered as a reset pulse that returns the block to active mode with no mode retained.

The latencies are parameters in reference-clock cycles. They include an extra memory power-up term that applies only when the memory was switched off and the wake needs it.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in active mode: `cpu_halt`=0, `mclk_en`=`aclk_en`=`lf_osc_en`=`hf_periph_en`=`accel_en`=1, `core_off`=0, `mem_state`=0 (on), `wake_rdy`=`wake_rst`=0, and `smclk_en` equals the inverse of `smclk_off`.
- R2: `req_mode` codes are: 0 active, 1 LPM0, 2 LPM1, 3 LPM2, 4 LPM3, 5 LPM4, 6 LPM3.5 and 7 LPM4.5. Any code from 8 to 15 is ignored, and the block stays active.
- R3: A valid request sampled at clock edge k moves the block into an entry cycle. The requested mode's gating is visible after edge k+1, and `cpu_halt` is 1 in every low-power mode.
- R4: `mclk_en` is 1 only in active mode and LPM0. `aclk_en` is 1 in active mode and LPM0 through LPM3. `hf_periph_en` is 1 in active mode, LPM0 and LPM1.
- R5: `smclk_en` is 1 only in active mode, LPM0 and LPM1, and only while `smclk_off` is 0.
- R6: `lf_osc_en` follows `aclk_en`. In LPM4 it is also 1 while `lf_clk_req` is 1.
- R7: The `wake_src` bits are: bit0 high-frequency or other source, bit1 low-frequency peripheral, bit2 RTC, bit3 I/O, bit4 comparator. The accepted sets are:
  - LPM0 and LPM1: all five bits.
  - LPM2 and LPM3: bits 1 to 4.
  - LPM4: bits 3 and 4.
  - LPM3.5: bits 2 and 3.
  - LPM4.5: bit 3 only.

  An event outside the set does not wake the block.
- R8: Wake events that arrive during the entry cycle are latched and accepted at the first sleeping edge.
- R9: A wake accepted at edge k raises `wake_rdy` for exactly one cycle, after edge k+D. D is:
  - 0 for LPM0.
  - `CYC_L12` for LPM1 and LPM2.
  - `CYC_L34` for LPM3 and LPM4.
  - `CYC_X5` for LPM3.5 and LPM4.5 when `svs_en`=1, and `CYC_X5_NOSVS` for those modes when `svs_en`=0.
- R10: In the retained modes, D is increased by `CYC_MEM` when `mem_off_en`=1 and `dma_only`=0. When `dma_only`=1, no extra latency is added.
- R11: In a retained mode the clocks return one cycle after `wake_rdy`. On `irq_ret`, the controller re-enters the same mode through the entry cycle if `req_mode` is nonzero, and goes to active mode if it is 0.
- R12: `core_off` is 1 only in LPM3.5 and LPM4.5. From these modes, `wake_rst` pulses together with `wake_rdy`, and the block is then active with no mode retained.
- R13: `mem_state` encodes 0 on, 1 standby, 2 off:
  - Active mode: on.
  - LPM0: off if `mem_off_en`, otherwise on.
  - LPM1: off if `mem_off_en`, otherwise standby.
  - LPM2 and deeper: off.
- R14: `accel_en` is 1 in active mode and LPM0. `accel_grant` follows `accel_start_req` only in active mode and is 0 in every low-power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mode | input | 4 | Mode request from CPU status bits |
| wake_src | input | 5 | Categorised wake events |
| irq_ret | input | 1 | Interrupt-return acknowledge |
| smclk_off | input | 1 | Forces the sub-system clock off |
| lf_clk_req | input | 1 | Low-frequency peripheral clock request |
| mem_off_en | input | 1 | Memory switched off before sleep |
| dma_only | input | 1 | Wake serves only a transfer into RAM |
| svs_en | input | 1 | Supply supervision enabled |
| accel_start_req | input | 1 | Signal-processing accelerator start request |
| mclk_en | output | 1 | Main clock gate enable |
| smclk_en | output | 1 | Sub-system clock gate enable |
| aclk_en | output | 1 | Auxiliary clock gate enable |
| lf_osc_en | output | 1 | Low-frequency oscillator enable |
| cpu_halt | output | 1 | CPU halted |
| hf_periph_en | output | 1 | High-frequency peripherals enabled |
| core_off | output | 1 | Core supply removed |
| mem_state | output | 2 | Memory power state |
| accel_en | output | 1 | Accelerator may run |
| accel_grant | output | 1 | Accelerator start accepted |
| wake_rst | output | 1 | Reset pulse on shutdown wake |
| wake_rdy | output | 1 | Wake latency expired strobe |

## Verification
Gating outputs change after the edge that enters sleep, which is one edge after the request is sampled. `wake_rdy` follows the accepting edge by exactly D edges, and clocks return one edge later. `accel_grant` is combinational from the current state. The bench drives inputs one time unit after the rising edge and compares every output against a behavioural model at the falling edge. Directed latency checks count rising edges from the edge that samples the wake event to the first falling edge that shows `wake_rdy`, and expect D+1.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int NSRC = 5;

    typedef enum logic [2:0] {
        M_AM  = 3'd0,
        M_L0  = 3'd1,
        M_L1  = 3'd2,
        M_L2  = 3'd3,
        M_L3  = 3'd4,
        M_L4  = 3'd5,
        M_L35 = 3'd6,
        M_L45 = 3'd7
    } pmode_e;

    typedef enum logic [2:0] {
        S_ACT   = 3'd0,
        S_ENTER = 3'd1,
        S_SLEEP = 3'd2,
        S_WAKE  = 3'd3,
        S_SVC   = 3'd4
    } pstate_e;

    typedef enum logic [1:0] {
        MEM_ON   = 2'd0,
        MEM_STBY = 2'd1,
        MEM_OFF  = 2'd2
    } memst_e;

    // bit0 hf/other, bit1 lf peripheral, bit2 rtc, bit3 i/o, bit4 comparator
    function automatic logic [NSRC-1:0] wake_mask(pmode_e m);
        logic [NSRC-1:0] v;
        case (m)
            M_L0, M_L1: v = 5'b11111;
            M_L2, M_L3: v = 5'b11110;
            M_L4:       v = 5'b11000;
            M_L35:      v = 5'b01100;
            M_L45:      v = 5'b01000;
            default:    v = 5'b00000;
        endcase
        return v;
    endfunction

    function automatic logic is_shutdown(pmode_e m);
        return (m == M_L35) || (m == M_L45);
    endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pmode_e       mode,
    input  logic         capture,
    input  logic         clear,
    input  logic         armed,
    input  logic [N-1:0] wake_in,
    output logic         hit
);
    typedef struct packed {
        logic [N-1:0] pend;
    } qst_t;

    qst_t r_q, r_d;
    logic [N-1:0] allow;

    always_comb begin
        allow = N'(wake_mask(mode));
        hit   = armed && (|((wake_in | r_q.pend) & allow));
        r_d   = r_q;
        if (clear)
            r_d.pend = '0;
        else if (capture)
            r_d.pend = r_q.pend | wake_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R8: events seen while capturing stay latched
    a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clear) |=> ((r_q.pend & $past(wake_in)) == $past(wake_in)));

endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tst_t;

    tst_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt  = load_val;
            r_d.done = (load_val == '0);
        end else begin
            r_d.done = (r_q.cnt == CW'(1));
            if (r_q.cnt != '0)
                r_d.cnt = r_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = r_q.done;

    // R9: ready strobe lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !load) |=> !r_q.done);

endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
    import lpm_pkg::*;
(
    input  pmode_e      em,
    input  logic        smclk_off,
    input  logic        lf_clk_req,
    input  logic        mem_off_en,
    input  logic        accel_start_req,
    output logic        mclk_en,
    output logic        smclk_en,
    output logic        aclk_en,
    output logic        lf_osc_en,
    output logic        cpu_halt,
    output logic        hf_periph_en,
    output logic        core_off,
    output logic [1:0]  mem_state,
    output logic        accel_en,
    output logic        accel_grant
);
    memst_e ms;

    always_comb begin
        mclk_en      = (em == M_AM) || (em == M_L0);
        hf_periph_en = (em == M_AM) || (em == M_L0) || (em == M_L1);
        smclk_en     = hf_periph_en && !smclk_off;
        aclk_en      = (em <= M_L3);
        lf_osc_en    = aclk_en || ((em == M_L4) && lf_clk_req);
        cpu_halt     = (em != M_AM);
        core_off     = is_shutdown(em);
        accel_en     = mclk_en;
        accel_grant  = accel_start_req && (em == M_AM);
        case (em)
            M_AM:    ms = MEM_ON;
            M_L0:    ms = mem_off_en ? MEM_OFF : MEM_ON;
            M_L1:    ms = mem_off_en ? MEM_OFF : MEM_STBY;
            default: ms = MEM_OFF;
        endcase
        mem_state = ms;
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int CYC_L12      = 6,
    parameter int CYC_L34      = 7,
    parameter int CYC_X5       = 25,
    parameter int CYC_X5_NOSVS = 100,
    parameter int CYC_MEM      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] req_mode,
    input  logic [4:0] wake_src,
    input  logic       irq_ret,
    input  logic       smclk_off,
    input  logic       lf_clk_req,
    input  logic       mem_off_en,
    input  logic       dma_only,
    input  logic       svs_en,
    input  logic       accel_start_req,
    output logic       mclk_en,
    output logic       smclk_en,
    output logic       aclk_en,
    output logic       lf_osc_en,
    output logic       cpu_halt,
    output logic       hf_periph_en,
    output logic       core_off,
    output logic [1:0] mem_state,
    output logic       accel_en,
    output logic       accel_grant,
    output logic       wake_rst,
    output logic       wake_rdy
);
    localparam int MAXD = (CYC_X5_NOSVS > CYC_X5) ? CYC_X5_NOSVS : CYC_X5;
    localparam int CW   = $clog2(MAXD + CYC_MEM + 1) + 1;

    typedef struct packed {
        pstate_e st;
        pmode_e  mode;
    } cst_t;

    cst_t r_q, r_d;

    logic          req_ok, hit, tmr_done, capture, clear, armed;
    logic [CW-1:0] base, extra, load_val;
    pmode_e        em;

    always_comb begin
        req_ok  = !req_mode[3] && (req_mode[2:0] != 3'd0);
        armed   = (r_q.st == S_SLEEP);
        capture = (r_q.st == S_ENTER) || armed;
        clear   = (r_q.st == S_ACT) || hit;
        em      = ((r_q.st == S_SLEEP) || (r_q.st == S_WAKE)) ? r_q.mode : M_AM;

        case (r_q.mode)
            M_L1, M_L2:   base = CW'(CYC_L12);
            M_L3, M_L4:   base = CW'(CYC_L34);
            M_L35, M_L45: base = svs_en ? CW'(CYC_X5) : CW'(CYC_X5_NOSVS);
            default:      base = '0;
        endcase
        extra    = (mem_off_en && !dma_only && !is_shutdown(r_q.mode)) ? CW'(CYC_MEM) : '0;
        load_val = base + extra;

        r_d = r_q;
        case (r_q.st)
            S_ACT: begin
                if (req_ok) begin
                    r_d.st   = S_ENTER;
                    r_d.mode = pmode_e'(req_mode[2:0]);
                end
            end
            S_ENTER: r_d.st = S_SLEEP;
            S_SLEEP: if (hit) r_d.st = S_WAKE;
            S_WAKE: begin
                if (tmr_done) begin
                    if (is_shutdown(r_q.mode)) begin
                        r_d.st   = S_ACT;
                        r_d.mode = M_AM;
                    end else begin
                        r_d.st = S_SVC;
                    end
                end
            end
            S_SVC: begin
                if (irq_ret) begin
                    if (req_mode == 4'd0) begin
                        r_d.st   = S_ACT;
                        r_d.mode = M_AM;
                    end else begin
                        r_d.st = S_ENTER;
                    end
                end
            end
            default: begin
                r_d.st   = S_ACT;
                r_d.mode = M_AM;
            end
        endcase

        wake_rst = tmr_done && (r_q.st == S_WAKE) && is_shutdown(r_q.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_ACT, mode: M_AM};
        else        r_q <= r_d;
    end

    lpm_wake_qual #(.N(NSRC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (r_q.mode),
        .capture (capture),
        .clear   (clear),
        .armed   (armed),
        .wake_in (wake_src),
        .hit     (hit)
    );

    lpm_wake_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hit),
        .load_val (load_val),
        .done     (tmr_done)
    );

    lpm_gate_dec u_gate (
        .em              (em),
        .smclk_off       (smclk_off),
        .lf_clk_req      (lf_clk_req),
        .mem_off_en      (mem_off_en),
        .accel_start_req (accel_start_req),
        .mclk_en         (mclk_en),
        .smclk_en        (smclk_en),
        .aclk_en         (aclk_en),
        .lf_osc_en       (lf_osc_en),
        .cpu_halt        (cpu_halt),
        .hf_periph_en    (hf_periph_en),
        .core_off        (core_off),
        .mem_state       (mem_state),
        .accel_en        (accel_en),
        .accel_grant     (accel_grant)
    );

    assign wake_rdy = tmr_done;

    // R2: undefined encodings leave the block active
    a_r2_undef_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == S_ACT) && req_mode[3]) |=> (r_q.st == S_ACT));

    // R12: reset pulse only out of a supply-off mode
    a_r12_rst_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |-> (core_off && wake_rdy));

    // R11: a retained wake leads to service on the next edge
    a_r11_to_service: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_rdy && !core_off) |=> (r_q.st == S_SVC) && !cpu_halt);

    // R14: no accelerator start while halted
    a_r14_grant_active: assert property (@(posedge clk) disable iff (!rst_n)
        accel_grant |-> !cpu_halt);

    // R4: running CPU sees its clocks
    a_r4_active_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_halt |-> (mclk_en && aclk_en && hf_periph_en && !core_off));

endmodule

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;
    localparam int P_L12 = 6, P_L34 = 7, P_X5 = 25, P_X5N = 100, P_MEM = 4;

    logic       clk = 0, rst_n = 0;
    logic [3:0] req_mode = 0;
    logic [4:0] wake_src = 0;
    logic irq_ret = 0, smclk_off = 0, lf_clk_req = 0, mem_off_en = 0;
    logic dma_only = 0, svs_en = 1, accel_start_req = 0;
    logic mclk_en, smclk_en, aclk_en, lf_osc_en, cpu_halt, hf_periph_en, core_off;
    logic [1:0] mem_state;
    logic accel_en, accel_grant, wake_rst, wake_rdy;

    int nchk = 0, nerr = 0, cyc = 0;

    always #5 clk = ~clk;

    lpm_ctrl #(.CYC_L12(P_L12), .CYC_L34(P_L34), .CYC_X5(P_X5),
               .CYC_X5_NOSVS(P_X5N), .CYC_MEM(P_MEM)) u_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .wake_src(wake_src),
        .irq_ret(irq_ret), .smclk_off(smclk_off), .lf_clk_req(lf_clk_req),
        .mem_off_en(mem_off_en), .dma_only(dma_only), .svs_en(svs_en),
        .accel_start_req(accel_start_req), .mclk_en(mclk_en), .smclk_en(smclk_en),
        .aclk_en(aclk_en), .lf_osc_en(lf_osc_en), .cpu_halt(cpu_halt),
        .hf_periph_en(hf_periph_en), .core_off(core_off), .mem_state(mem_state),
        .accel_en(accel_en), .accel_grant(accel_grant), .wake_rst(wake_rst),
        .wake_rdy(wake_rdy));

    // behavioural reference
    int ph = 0, md = 0, mcnt = 0, mpend = 0;
    bit mrdy = 0;

    function automatic int allowed(int m);
        case (m)
            1, 2: return 31;
            3, 4: return 30;
            5:    return 24;
            6:    return 12;
            7:    return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int latency(int m);
        int d;
        if (m == 1) d = 0;
        else if (m <= 3) d = P_L12;
        else if (m <= 5) d = P_L34;
        else d = svs_en ? P_X5 : P_X5N;
        if (m <= 5 && mem_off_en && !dma_only) d += P_MEM;
        return d;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; md = 0; mcnt = 0; mpend = 0; mrdy = 0;
        end else begin
            bit nr;
            int w, d;
            nr = 0;
            if (mcnt > 0) begin mcnt--; if (mcnt == 0) nr = 1; end
            case (ph)
                0: begin
                    mpend = 0;
                    if (req_mode != 0 && req_mode < 8) begin ph = 1; md = int'(req_mode); end
                end
                1: begin mpend |= int'(wake_src); ph = 2; end
                2: begin
                    w = (int'(wake_src) | mpend) & allowed(md);
                    if (w != 0) begin
                        mpend = 0; d = latency(md); ph = 3;
                        if (d == 0) nr = 1; else mcnt = d;
                    end else mpend |= int'(wake_src);
                end
                3: if (mrdy) begin
                    if (md >= 6) begin ph = 0; md = 0; end else ph = 4;
                end
                default: if (irq_ret) begin
                    if (req_mode == 0) begin ph = 0; md = 0; end else ph = 1;
                end
            endcase
            mrdy = nr;
        end
    end

    task automatic chk(string tag, string nm, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int em, ms;
            em = (ph == 2 || ph == 3) ? md : 0;
            ms = (em == 0) ? 0 : (em == 1) ? (mem_off_en ? 2 : 0)
               : (em == 2) ? (mem_off_en ? 2 : 1) : 2;
            chk("R4", "mclk_en", mclk_en, em <= 1);
            chk("R5", "smclk_en", smclk_en, em <= 2 && !smclk_off);
            chk("R4", "aclk_en", aclk_en, em <= 4);
            chk("R6", "lf_osc_en", lf_osc_en, em <= 4 || (em == 5 && lf_clk_req));
            chk("R3", "cpu_halt", cpu_halt, em != 0);
            chk("R4", "hf_periph_en", hf_periph_en, em <= 2);
            chk("R12", "core_off", core_off, em >= 6);
            chk("R13", "mem_state", int'(mem_state), ms);
            chk("R14", "accel_en", accel_en, em <= 1);
            chk("R14", "accel_grant", accel_grant, accel_start_req && em == 0);
            chk("R9", "wake_rdy", wake_rdy, mrdy);
            chk("R12", "wake_rst", wake_rst, ph == 3 && mrdy && md >= 6);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic go_sleep(int m);
        req_mode = 4'(m); step(2);
    endtask

    // pulse wake, count edges until wake_rdy; expect D+1
    task automatic wake_time(logic [4:0] src, int d, string tag);
        int n;
        bit seen;
        wake_src = src; n = 0; seen = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(posedge clk); n++; #1 wake_src = 0;
            @(negedge clk);
            if (wake_rdy) seen = 1;
        end
        chk(tag, "wake latency edges", n, d + 1);
    endtask

    task automatic ret(int nreq);
        step(1);
        req_mode = 4'(nreq); irq_ret = 1; step(1); irq_ret = 0;
    endtask

    initial begin
        step(2); rst_n = 1; step(1);
        // R1 reset state
        chk("R1", "cpu_halt", cpu_halt, 0);
        chk("R1", "mclk_en", mclk_en, 1);
        chk("R1", "mem_state", int'(mem_state), 0);
        chk("R1", "wake_rdy", wake_rdy, 0);

        // R2 undefined encoding
        req_mode = 4'd9; step(4);
        chk("R2", "cpu_halt after code 9", cpu_halt, 0);
        req_mode = 4'd15; step(3);
        chk("R2", "cpu_halt after code 15", cpu_halt, 0);

        // LPM0: accelerator, immediate wake, re-entry
        req_mode = 4'd1; step(1);
        chk("R3", "cpu_halt in entry cycle", cpu_halt, 0);
        step(1);
        chk("R3", "cpu_halt in LPM0", cpu_halt, 1);
        chk("R4", "mclk_en in LPM0", mclk_en, 1);
        accel_start_req = 1; #1;
        chk("R14", "grant rejected in LPM0", accel_grant, 0);
        accel_start_req = 0;
        wake_time(5'b01000, 0, "R9");
        ret(1); step(1);
        chk("R11", "re-entered LPM0", cpu_halt, 1);
        wake_time(5'b00001, 0, "R9");
        ret(0); step(1);
        chk("R11", "back to active", cpu_halt, 0);
        accel_start_req = 1; #1;
        chk("R14", "grant in active", accel_grant, 1);
        accel_start_req = 0;

        // LPM2: disallowed source then LF peripheral
        go_sleep(3);
        chk("R4", "smclk off in LPM2", smclk_en, 0);
        chk("R4", "aclk on in LPM2", aclk_en, 1);
        wake_src = 5'b00001; step(1); wake_src = 0; step(8);
        chk("R7", "hf source ignored in LPM2", cpu_halt, 1);
        wake_time(5'b00010, P_L12, "R9");
        ret(0);

        // LPM4 with LF request and memory off
        lf_clk_req = 1; mem_off_en = 1; dma_only = 0;
        go_sleep(5);
        chk("R6", "lf osc kept in LPM4", lf_osc_en, 1);
        chk("R4", "aclk off in LPM4", aclk_en, 0);
        wake_src = 5'b00100; step(1); wake_src = 0; step(6);
        chk("R7", "rtc ignored in LPM4", cpu_halt, 1);
        wake_time(5'b10000, P_L34 + P_MEM, "R10");
        ret(0); lf_clk_req = 0;

        // LPM3 with event during entry, dma-only wake
        dma_only = 1;
        req_mode = 4'd4; step(1);
        wake_src = 5'b00100; step(1); wake_src = 0;
        wake_time(5'b00000, P_L34, "R8");
        ret(0); mem_off_en = 0; dma_only = 0;

        // LPM1: SMCLK control
        go_sleep(2);
        chk("R5", "smclk in LPM1", smclk_en, 1);
        chk("R13", "standby in LPM1", int'(mem_state), 1);
        smclk_off = 1; #1;
        chk("R5", "smclk forced off", smclk_en, 0);
        wake_time(5'b00001, P_L12, "R9");
        ret(0); smclk_off = 0;

        // LPM3.5 with supervision
        svs_en = 1;
        go_sleep(6);
        chk("R12", "core off in LPM3.5", core_off, 1);
        wake_src = 5'b10000; step(1); wake_src = 0; step(5);
        chk("R7", "comparator ignored in LPM3.5", core_off, 1);
        wake_time(5'b00100, P_X5, "R12");
        chk("R12", "reset pulse", wake_rst, 1);
        #1 req_mode = 0; step(1);
        chk("R12", "active after shutdown wake", cpu_halt, 0);

        // LPM4.5 without supervision
        svs_en = 0;
        go_sleep(7);
        wake_src = 5'b00100; step(1); wake_src = 0; step(5);
        chk("R7", "rtc ignored in LPM4.5", core_off, 1);
        wake_time(5'b01000, P_X5N, "R12");
        chk("R12", "reset pulse 4.5", wake_rst, 1);
        #1 req_mode = 0; step(2);
        chk("R12", "no retained mode", cpu_halt, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule